// File: doc/BRIEF.md
# IR receive run-length sampler

This block turns a demodulated infrared line into a stream of run-length symbols. On every sample tick it looks at the line, after an optional polarity inversion, and measures how many consecutive ticks the line keeps the same level. Each finished run becomes one byte: the top bit says whether it was a pulse (carrier present) or a space, and the low seven bits hold the run length in ticks. Runs too long for seven bits are cut into full-length pieces followed by the remainder. A packet opens on the first pulse and closes once a space has lasted for a programmable number of ticks.

Symbols are queued in a 32-entry receive FIFO with a show-ahead read port and a flush control. An 8-bit sticky status register records data arrival, trigger-level crossings, packet end and overruns. Software clears bits by writing ones. An 8-bit enable mask reduces the status to a single interrupt line. The sample tick comes from outside, so the sample period (1, 25, 50 or 100 µs in typical use) is set by whatever drives the tick.

Top module: `ir_rl_sampler`

## Requirements
- R1: Each symbol is one byte. Bit 7 is 1 for a pulse and 0 for a space, and bits 6:0 give the run length in sample ticks (never zero). A pulse is a sampled level of 1 after the optional inversion.
- R2: A run reaching 127 ticks emits a symbol with length 0x7F and restarts counting. When the level changes, only the non-zero remainder is emitted, so a run that is an exact multiple of 127 produces no zero-length symbol.
- R3: The FIFO holds 32 symbols. A symbol pushed while it is full is dropped, and this sets status bit 4 (overrun) together with bit 7 (data ready).
- R4: With `invert_en` high the line is inverted before sampling, so a low line counts as a pulse.
- R5: Spaces before the first pulse of a packet produce nothing. Inside a packet, once the current space run reaches `sample_limit` ticks (limits below 2 act as 2), the space run is emitted, status bit 5 (packet end) is set, and the block waits for the next pulse.
- R6: Every symbol accepted into the FIFO sets status bit 7 (data ready).
- R7: When an accepted symbol leaves the FIFO count at or above a non-zero `rx_trig`, status bit 6 (trigger reached) is set.
- R8: Writing `sts_wdata` with `sts_wr` high clears every status bit written as 1. A bit set by an event in the same cycle stays set. Bits 3:0 always read 0.
- R9: `irq` is high exactly when `status & irq_en` is non-zero.
- R10: `fifo_clr` empties the FIFO. `rd_data` shows the oldest symbol, and `rd_en` removes it. `rd_en` on an empty FIFO has no effect.
- R11: Only cycles with `sample_tick` high advance the sampler. Results appear at the clock edge that samples the tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ir_in | input | 1 | Demodulated IR line |
| sample_tick | input | 1 | One-cycle strobe per sample period |
| invert_en | input | 1 | Invert the line before sampling |
| sample_limit | input | 16 | Space length in ticks that ends a packet |
| rx_trig | input | 6 | FIFO level for the trigger flag, 0 disables it |
| fifo_clr | input | 1 | Flush the receive FIFO |
| rd_en | input | 1 | Pop the oldest symbol |
| rd_data | output | 8 | Oldest symbol (show-ahead) |
| rx_count | output | 6 | Number of stored symbols |
| sts_wr | input | 1 | Write strobe for status clearing |
| sts_wdata | input | 8 | Bits to clear in the status register |
| irq_en | input | 8 | Interrupt enable mask |
| status | output | 8 | Sticky status flags |
| irq | output | 1 | Interrupt request |

## Verification
Every result is registered at the same clock edge that samples its stimulus: a ticked sample, a pop, a flush or a status write. Symbol, count and flag changes are therefore due one edge after the inputs are applied. The bench drives inputs on the falling edge and samples on the next falling edge, exactly one rising edge later. The show-ahead read data is compared before the popping edge, and `irq` is checked together with the status it depends on.

// File: rtl/ir_rl_pkg.sv
package ir_rl_pkg;
    localparam int SYM_W = 8;
    localparam int LEN_W = 7;
    localparam int STS_W = 8;

    // status bit positions (order is externally visible)
    localparam int BIT_RDR  = 7;
    localparam int BIT_TRIG = 6;
    localparam int BIT_PEND = 5;
    localparam int BIT_OVR  = 4;

    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    typedef logic [SYM_W-1:0] sym_t;
endpackage

// File: rtl/ir_rl_encoder.sv
module ir_rl_encoder
    import ir_rl_pkg::*;
#(
    parameter int LIMIT_W = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_in,
    input  logic               tick,
    input  logic               invert_en,
    input  logic [LIMIT_W-1:0] limit,
    output logic               push,
    output sym_t               sym,
    output logic               pkt_end
);
    typedef struct packed {
        logic               in_pkt;
        logic               cur;
        logic [LEN_W-1:0]   run;
        logic [LIMIT_W-1:0] idle;
    } enc_st_t;

    enc_st_t q, d;
    logic               lvl;
    logic [LEN_W-1:0]   run_inc;
    logic [LIMIT_W-1:0] idle_inc;

    always_comb begin
        d        = q;
        push     = 1'b0;
        sym      = '0;
        pkt_end  = 1'b0;
        lvl      = ir_in ^ invert_en;
        run_inc  = q.run + LEN_W'(1);
        idle_inc = q.idle + LIMIT_W'(1);
        if (tick) begin
            if (!q.in_pkt) begin
                if (lvl) begin
                    d.in_pkt = 1'b1;
                    d.cur    = 1'b1;
                    d.run    = LEN_W'(1);
                    d.idle   = '0;
                end
            end else if (lvl == q.cur) begin
                if (run_inc == LEN_MAX) begin
                    push  = 1'b1;
                    sym   = {q.cur, LEN_MAX};
                    d.run = '0;
                end else begin
                    d.run = run_inc;
                end
                if (!q.cur) begin
                    d.idle = idle_inc;
                    if (idle_inc >= limit) begin
                        pkt_end = 1'b1;
                        if (run_inc != LEN_MAX) begin
                            push = 1'b1;
                            sym  = {1'b0, run_inc};
                        end
                        d.run    = '0;
                        d.in_pkt = 1'b0;
                        d.idle   = '0;
                    end
                end
            end else begin
                if (q.run != '0) begin
                    push = 1'b1;
                    sym  = {q.cur, q.run};
                end
                d.cur  = lvl;
                d.run  = LEN_W'(1);
                d.idle = lvl ? '0 : LIMIT_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    p_push_on_tick_r11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> tick);
    p_len_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (sym[LEN_W-1:0] != '0));
    p_run_below_max_r2: assert property (@(posedge clk) disable iff (!rst_n)
        q.run != LEN_MAX);
    p_pend_space_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pkt_end && push) |-> !sym[SYM_W-1]);
endmodule

// File: rtl/ir_rl_fifo.sv
module ir_rl_fifo
    import ir_rl_pkg::*;
#(
    parameter int DEPTH = 32,
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  sym_t             wdata,
    input  logic             pop,
    input  logic             clr,
    output sym_t             rdata,
    output logic [CNT_W-1:0] count,
    output logic [CNT_W-1:0] next_cnt,
    output logic             accepted,
    output logic             overflow
);
    typedef struct {
        sym_t             mem [DEPTH];
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [CNT_W-1:0] cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic     full;
    logic     do_pop;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + PTR_W'(1);
    endfunction

    always_comb begin
        d        = q;
        full     = (q.cnt == CNT_W'(DEPTH));
        do_pop   = pop && (q.cnt != '0) && !clr;
        accepted = push && !full && !clr;
        overflow = push && full && !clr;
        if (clr) begin
            d.wp  = '0;
            d.rp  = '0;
            d.cnt = '0;
        end else begin
            if (accepted) begin
                d.mem[q.wp] = wdata;
                d.wp        = ptr_next(q.wp);
            end
            if (do_pop) d.rp = ptr_next(q.rp);
            case ({accepted, do_pop})
                2'b10:   d.cnt = q.cnt + CNT_W'(1);
                2'b01:   d.cnt = q.cnt - CNT_W'(1);
                default: d.cnt = q.cnt;
            endcase
        end
        next_cnt = d.cnt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) q.mem[i] <= '0;
            q.wp  <= '0;
            q.rp  <= '0;
            q.cnt <= '0;
        end else begin
            q <= d;
        end
    end

    assign rdata = q.mem[q.rp];
    assign count = q.cnt;

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CNT_W'(DEPTH));
    p_clear_empties_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (q.cnt == '0));
    p_pop_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.cnt == '0 && !push) |=> (q.cnt == '0));
    p_full_holds_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !clr) |=> (q.cnt == CNT_W'(DEPTH)));
endmodule

// File: rtl/ir_rl_status.sv
module ir_rl_status
    import ir_rl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_rdr,
    input  logic             set_trig,
    input  logic             set_pend,
    input  logic             set_ovr,
    input  logic             clr_we,
    input  logic [STS_W-1:0] clr_mask,
    input  logic [STS_W-1:0] irq_en,
    output logic [STS_W-1:0] status,
    output logic             irq
);
    logic [STS_W-1:0] q, d;
    logic [STS_W-1:0] set_v;

    always_comb begin
        set_v           = '0;
        set_v[BIT_RDR]  = set_rdr;
        set_v[BIT_TRIG] = set_trig;
        set_v[BIT_PEND] = set_pend;
        set_v[BIT_OVR]  = set_ovr;
        d = (q & ~(clr_we ? clr_mask : '0)) | set_v;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign status = q;
    assign irq    = |(q & irq_en);

    p_ovr_with_rdr_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q[BIT_OVR]) |-> q[BIT_RDR]);
    p_w1c_r8: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> ((q & $past(clr_mask & ~set_v)) == '0));
    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_rdr |=> q[BIT_RDR]);
endmodule

// File: rtl/ir_rl_sampler.sv
module ir_rl_sampler
    import ir_rl_pkg::*;
#(
    parameter int DEPTH   = 32,
    parameter int LIMIT_W = 16,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ir_in,
    input  logic               sample_tick,
    input  logic               invert_en,
    input  logic [LIMIT_W-1:0] sample_limit,
    input  logic [CNT_W-1:0]   rx_trig,
    input  logic               fifo_clr,
    input  logic               rd_en,
    output logic [SYM_W-1:0]   rd_data,
    output logic [CNT_W-1:0]   rx_count,
    input  logic               sts_wr,
    input  logic [STS_W-1:0]   sts_wdata,
    input  logic [STS_W-1:0]   irq_en,
    output logic [STS_W-1:0]   status,
    output logic               irq
);
    logic             enc_push;
    sym_t             enc_sym;
    logic             enc_pend;
    logic             f_acc;
    logic             f_ovf;
    logic [CNT_W-1:0] f_next;
    logic             trig_hit;

    ir_rl_encoder #(.LIMIT_W(LIMIT_W)) u_enc (
        .clk       (clk),
        .rst_n     (rst_n),
        .ir_in     (ir_in),
        .tick      (sample_tick),
        .invert_en (invert_en),
        .limit     (sample_limit),
        .push      (enc_push),
        .sym       (enc_sym),
        .pkt_end   (enc_pend)
    );

    ir_rl_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (enc_push),
        .wdata    (enc_sym),
        .pop      (rd_en),
        .clr      (fifo_clr),
        .rdata    (rd_data),
        .count    (rx_count),
        .next_cnt (f_next),
        .accepted (f_acc),
        .overflow (f_ovf)
    );

    assign trig_hit = f_acc && (rx_trig != '0) && (f_next >= rx_trig);

    ir_rl_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_rdr  (f_acc || f_ovf),
        .set_trig (trig_hit),
        .set_pend (enc_pend),
        .set_ovr  (f_ovf),
        .clr_we   (sts_wr),
        .clr_mask (sts_wdata),
        .irq_en   (irq_en),
        .status   (status),
        .irq      (irq)
    );

    p_count_needs_event_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!sample_tick && !rd_en && !fifo_clr) |=> $stable(rx_count));
endmodule

// File: tb/ir_rl_sampler_bench.sv
module ir_rl_sampler_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ir_in = 1'b0, sample_tick = 1'b0, invert_en = 1'b0;
    logic [15:0] sample_limit = 16'd20;
    logic [5:0]  rx_trig = 6'd4;
    logic        fifo_clr = 1'b0, rd_en = 1'b0, sts_wr = 1'b0;
    logic [7:0]  sts_wdata = '0, irq_en = '0;
    logic [7:0]  rd_data, status;
    logic [5:0]  rx_count;
    logic        irq;

    always #(CLK_PERIOD/2) clk = ~clk;

    ir_rl_sampler u_ir_rl_sampler (
        .clk(clk), .rst_n(rst_n), .ir_in(ir_in), .sample_tick(sample_tick),
        .invert_en(invert_en), .sample_limit(sample_limit), .rx_trig(rx_trig),
        .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_data(rd_data), .rx_count(rx_count),
        .sts_wr(sts_wr), .sts_wdata(sts_wdata), .irq_en(irq_en),
        .status(status), .irq(irq)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    // reference model state
    logic [7:0] mq[$];
    logic [7:0] m_sts = '0;
    bit m_in = 0, m_cur = 0;
    int m_run = 0, m_idle = 0;

    function automatic logic [7:0] mk_sym(input bit pulse, input int len);
        return {pulse, len[6:0]};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic m_push(input logic [7:0] s);
        if (mq.size() == 32) begin
            m_sts[7] = 1; m_sts[4] = 1;
        end else begin
            mq.push_back(s);
            m_sts[7] = 1;
            if (rx_trig != 0 && mq.size() >= int'(rx_trig)) m_sts[6] = 1;
        end
    endtask

    task automatic m_tick(input bit lvl);
        int nr;
        if (!m_in) begin
            if (lvl) begin m_in = 1; m_cur = 1; m_run = 1; m_idle = 0; end
        end else if (lvl == m_cur) begin
            nr = m_run + 1;
            if (nr == 127) begin m_push(mk_sym(m_cur, 127)); m_run = 0; end
            else m_run = nr;
            if (!m_cur) begin
                m_idle++;
                if (m_idle >= int'(sample_limit)) begin
                    m_sts[5] = 1;
                    if (nr != 127) m_push(mk_sym(0, nr));
                    m_run = 0; m_in = 0; m_idle = 0;
                end
            end
        end else begin
            if (m_run != 0) m_push(mk_sym(m_cur, m_run));
            m_cur = lvl; m_run = 1; m_idle = lvl ? 0 : 1;
        end
    endtask

    task automatic tick(input bit ir);
        ir_in = ir; sample_tick = 1;
        @(negedge clk);
        sample_tick = 0;
        m_tick(ir ^ invert_en);
    endtask

    task automatic run(input bit ir, input int n);
        for (int i = 0; i < n; i++) tick(ir);
    endtask

    task automatic check_state(input string req);
        chk({req, " status"}, status, m_sts);
        chk({req, " count"}, rx_count, mq.size());
        chk({req, " irq R9"}, irq, |(m_sts & irq_en));
    endtask

    task automatic pop_chk(input string req);
        chk(req, rd_data, mq[0]);
        rd_en = 1; @(negedge clk); rd_en = 0;
        void'(mq.pop_front());
    endtask

    task automatic pop_lit(input string req, input logic [7:0] exp);
        chk(req, rd_data, exp);
        rd_en = 1; @(negedge clk); rd_en = 0;
        void'(mq.pop_front());
    endtask

    task automatic drain(input string req);
        while (mq.size() > 0) pop_chk(req);
    endtask

    task automatic w1c(input logic [7:0] m);
        sts_wr = 1; sts_wdata = m; @(negedge clk); sts_wr = 0;
        m_sts &= ~m;
    endtask

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        check_state("reset");

        // R5: spaces before the first pulse produce nothing
        irq_en = 8'h20;
        run(0, 30);
        chk("R5 idle before packet", rx_count, 0);

        // R1 R2 R5 R6 R7: directed packet
        run(1, 5); run(0, 3); run(1, 130); run(0, 20);
        check_state("R5 R6 R7 packet");
        chk("R5 packet end bit", status[5], 1);
        chk("R7 trigger bit", status[6], 1);
        pop_lit("R1 pulse 5", 8'h85);
        pop_lit("R1 space 3", 8'h03);
        pop_lit("R2 split full", 8'hFF);
        pop_lit("R2 remainder", 8'h83);
        pop_lit("R5 final space", 8'h14);
        // R10: pop on empty does nothing
        rd_en = 1; @(negedge clk); rd_en = 0;
        chk("R10 pop empty", rx_count, 0);

        // R8: partial clear then full clear, irq follows (R9)
        w1c(8'h20);
        check_state("R8 clear pend");
        chk("R8 rdr kept", status[7], 1);
        w1c(8'hFF);
        check_state("R8 clear all");

        // R2: exact 127 multiple emits no zero-length remainder
        run(1, 254); run(0, 20);
        pop_lit("R2 exact a", 8'hFF);
        pop_lit("R2 exact b", 8'hFF);
        pop_lit("R2 exact space", 8'h14);
        chk("R2 no extra", rx_count, 0);
        w1c(8'hFF);

        // R11: toggling line without ticks changes nothing
        ir_in = 1; sample_tick = 0;
        repeat (4) begin @(negedge clk); ir_in = ~ir_in; end
        check_state("R11 no tick");

        // R4: inverted polarity
        invert_en = 1;
        run(0, 10); run(1, 20);
        pop_lit("R4 inverted pulse", 8'h8A);
        pop_lit("R4 inverted space", 8'h14);
        invert_en = 0;
        w1c(8'hFF);

        // R8: event in same cycle as a clear-all keeps its bit
        run(1, 3);
        sts_wr = 1; sts_wdata = 8'hFF;
        m_sts = '0;
        tick(0);
        sts_wr = 0;
        check_state("R8 set wins");
        chk("R8 set wins rdr", status[7], 1);

        // R3: overrun with a full FIFO
        sample_limit = 16'd1000;
        irq_en = 8'h10;
        for (int i = 0; i < 45; i++) tick(i[0]);
        check_state("R3 overrun");
        chk("R3 full count", rx_count, 32);
        chk("R3 ovr bit", status[4], 1);
        chk("R3 low bits zero R8", int'(status[3:0]), 0);
        drain("R3 stored order");
        w1c(8'hFF);

        // R10: flush
        for (int i = 0; i < 6; i++) tick(i[0]);
        fifo_clr = 1; @(negedge clk); fifo_clr = 0;
        mq.delete();
        chk("R10 flush", rx_count, 0);
        w1c(8'hFF);
        run(0, 1100);
        drain("R10 after flush");
        w1c(8'hFF);
        check_state("R10 idle");

        // random packets
        irq_en = 8'hE0;
        for (int p = 0; p < 40; p++) begin
            sample_limit = 16'($urandom_range(2, 200));
            rx_trig = 6'($urandom_range(0, 12));
            for (int r = 0; r < int'($urandom_range(1, 6)); r++) begin
                run(1, $urandom_range(1, 140));
                run(0, $urandom_range(1, 140));
            end
            run(0, int'(sample_limit) + 2);
            check_state("R1 R5 R7 random");
            drain("R1 R2 random data");
            w1c(8'($urandom_range(0, 255)));
            check_state("R8 random clear");
            w1c(8'hFF);
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule